// File: doc/BRIEF.md
# ADC Result Word Formatter

This block sits directly behind a delta-sigma decimation filter and turns each filtered conversion result into a 24-bit output word. Each incoming result is a signed two's complement value, counted in LSBs of the selected result width. The block clamps the value into the code range of that width. It places the clamped code left-justified in the output word and fills the lowest nibble with two status flags.

There are two status flags. The overrange flag describes only the word it travels with. The modulator-unstable flag is sticky: it stays set on the word taken while the filter reports instability and on a fixed number of words after that. A control pin picks either a 20-bit or a 16-bit result per word.

Results enter and leave through valid/ready streams. An input beat is taken when `in_valid` and `in_ready` are both high. `in_ready` is high whenever the single output register is empty or is being drained in the same cycle. While `out_valid` is high and `out_ready` is low, the output word is held unchanged and no new input is taken.

Top module: `adc_word_fmt`

## Requirements
- R1: In 20-bit mode (`in_mode` = 0) the clamped code occupies `out_word[23:4]`. Bit 2 is the overrange flag, bit 1 is the unstable flag, and bits 3 and 0 are zero.
- R2: In 16-bit mode (`in_mode` = 1) the clamped code occupies `out_word[23:8]` and bits 7 to 4 are zero. The low nibble uses the same flag layout as R1.
- R3: In 20-bit mode a value above 524287 yields the code 0x7FFFF, and a value below -524288 yields the code 0x80000. Both limit values themselves pass through unchanged.
- R4: In 16-bit mode a value above 32767 yields the code 0x7FFF, and a value below -32768 yields the code 0x8000.
- R5: The overrange flag is set on a word when the value lay outside the mode's code range or `in_ovr` was high with that beat. It is recomputed for every word and is never sticky.
- R6: The unstable flag is set on every word taken with `in_unstable` high. It is also set on the next 4 words taken with `in_unstable` low, and it is clear on the 5th such word.
- R7: A beat with `in_unstable` high during the holdoff restarts the count, so 4 further flagged words follow it.
- R8: The two flags are independent. An unstable beat with an in-range value gives unstable=1 with overrange=0. An overrange beat with no instability pending gives overrange=1 with unstable=0.
- R9: `out_valid` rises the cycle after an accepted beat. `in_ready` equals `!out_valid || out_ready`. While stalled, `out_word` holds its value.
- R10: A synchronous active-high reset clears `out_valid`, `out_word` and the holdoff. The first stable word after reset carries unstable=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_mode | input | 1 | Result width for the beat: 0 = 20-bit, 1 = 16-bit |
| in_valid | input | 1 | Input beat valid |
| in_ready | output | 1 | Block can take an input beat |
| in_value | input | IN_W (24) | Signed filter result, in result LSBs |
| in_ovr | input | 1 | Filter reports overrange for this beat |
| in_unstable | input | 1 | Modulator reported unstable for this beat |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Consumer takes the output word |
| out_word | output | 24 | Packed code and flags |

## Verification
The hardest case to reach is instability that comes back while the holdoff is still running. Reaching it needs an exact count of accepted words between two unstable beats. The directed task sends one unstable beat, then two stable ones, then a second unstable beat. It then walks the word count past the reloaded holdoff and expects the clear on the fifth stable word. A second hard case is a stall on a held word: the bench drops `out_ready` and offers a new beat. It then confirms that the beat is refused and that the word keeps its value.

// File: rtl/adc_word_fmt_pkg.sv
package adc_word_fmt_pkg;
  localparam int WORD_W     = 24;
  localparam int RES20_W    = 20;
  localparam int RES16_W    = 16;
  localparam int FLAG_W     = 4;
  localparam int BIT_OF     = 2;
  localparam int BIT_OD     = 1;

  typedef enum logic {
    MODE_20 = 1'b0,
    MODE_16 = 1'b1
  } res_mode_e;

  typedef struct packed {
    logic over;
    logic unstable;
  } flags_t;
endpackage

// File: rtl/adc_word_sat.sv
module adc_word_sat
  import adc_word_fmt_pkg::*;
#(
  parameter int IN_W = 24
) (
  input  logic signed [IN_W-1:0]    value,
  input  res_mode_e                 mode,
  output logic [RES20_W-1:0]        code_lj,
  output logic                      range_err
);
  localparam logic signed [IN_W-1:0] HI20 = {{(IN_W-RES20_W+1){1'b0}}, {(RES20_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] LO20 = ~HI20;
  localparam logic signed [IN_W-1:0] HI16 = {{(IN_W-RES16_W+1){1'b0}}, {(RES16_W-1){1'b1}}};
  localparam logic signed [IN_W-1:0] LO16 = ~HI16;
  localparam int PAD16 = RES20_W - RES16_W;

  logic signed [IN_W-1:0] hi_lim, lo_lim, clamped;
  logic above, below;

  always_comb begin
    hi_lim = (mode == MODE_16) ? HI16 : HI20;
    lo_lim = (mode == MODE_16) ? LO16 : LO20;
    above  = value > hi_lim;
    below  = value < lo_lim;
    if (above)      clamped = hi_lim;
    else if (below) clamped = lo_lim;
    else            clamped = value;
    range_err = above | below;
    if (mode == MODE_16) code_lj = {clamped[RES16_W-1:0], {PAD16{1'b0}}};
    else                 code_lj = clamped[RES20_W-1:0];
  end
endmodule

// File: rtl/adc_word_od_track.sv
module adc_word_od_track #(
  parameter int HOLD_WORDS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic take,
  input  logic unstable,
  output logic od_now
);
  localparam int CNT_W = $clog2(HOLD_WORDS + 1);
  localparam logic [CNT_W-1:0] HOLD_LD = CNT_W'(HOLD_WORDS);

  logic [CNT_W-1:0] cnt;

  assign od_now = unstable | (cnt != '0);

  always_ff @(posedge clk) begin
    if (rst)                        cnt <= '0;
    else if (take && unstable)      cnt <= HOLD_LD;
    else if (take && cnt != '0)     cnt <= cnt - 1'b1;
  end

  assert_cnt_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt <= HOLD_LD);

  assert_idle_keeps_R6: assert property (@(posedge clk) disable iff (rst)
    !take |=> $stable(cnt));
endmodule

// File: rtl/adc_word_pack.sv
module adc_word_pack
  import adc_word_fmt_pkg::*;
(
  input  logic [RES20_W-1:0] code_lj,
  input  flags_t             flags,
  output logic [WORD_W-1:0]  word
);
  always_comb begin
    word = '0;
    word[WORD_W-1 -: RES20_W] = code_lj;
    word[BIT_OF] = flags.over;
    word[BIT_OD] = flags.unstable;
  end
endmodule

// File: rtl/adc_word_fmt.sv
module adc_word_fmt
  import adc_word_fmt_pkg::*;
#(
  parameter int IN_W       = 24,
  parameter int HOLD_WORDS = 4
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_mode,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [IN_W-1:0]        in_value,
  input  logic                   in_ovr,
  input  logic                   in_unstable,
  output logic                   out_valid,
  input  logic                   out_ready,
  output logic [WORD_W-1:0]      out_word
);
  logic              take;
  logic [RES20_W-1:0] code_lj;
  logic              range_err;
  logic              od_now;
  flags_t            flags;
  logic [WORD_W-1:0] packed_word;
  res_mode_e         mode;

  assign mode     = res_mode_e'(in_mode);
  assign in_ready = !out_valid || out_ready;
  assign take     = in_valid && in_ready;

  adc_word_sat #(.IN_W(IN_W)) u_sat (
    .value     ($signed(in_value)),
    .mode      (mode),
    .code_lj   (code_lj),
    .range_err (range_err)
  );

  adc_word_od_track #(.HOLD_WORDS(HOLD_WORDS)) u_od (
    .clk      (clk),
    .rst      (rst),
    .take     (take),
    .unstable (in_unstable),
    .od_now   (od_now)
  );

  always_comb begin
    flags.over     = range_err | in_ovr;
    flags.unstable = od_now;
  end

  adc_word_pack u_pack (
    .code_lj (code_lj),
    .flags   (flags),
    .word    (packed_word)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_word  <= '0;
    end else if (take) begin
      out_valid <= 1'b1;
      out_word  <= packed_word;
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  assert_stall_hold_R9: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_word));

  assert_valid_after_take_R9: assert property (@(posedge clk) disable iff (rst)
    take |=> out_valid);

  assert_unstable_flag_R6: assert property (@(posedge clk) disable iff (rst)
    take && in_unstable |=> out_word[BIT_OD]);

  assert_ovr_flag_R5: assert property (@(posedge clk) disable iff (rst)
    take && in_ovr |=> out_word[BIT_OF]);

  assert_pos_clamp_R3: assert property (@(posedge clk) disable iff (rst)
    take && !in_mode && !in_value[IN_W-1] && (|in_value[IN_W-2:RES20_W-1])
      |=> out_word[WORD_W-1 -: RES20_W] == 20'h7FFFF);

  assert_pos_clamp_R4: assert property (@(posedge clk) disable iff (rst)
    take && in_mode && !in_value[IN_W-1] && (|in_value[IN_W-2:RES16_W-1])
      |=> out_word[WORD_W-1 -: RES20_W] == 20'h7FFF0);

  assert_nibble_zero_R1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !out_word[3] && !out_word[0]);
endmodule

// File: tb/sim_adc_word_fmt.sv
module sim_adc_word_fmt;
  logic        clk = 0;
  logic        rst;
  logic        in_mode, in_valid, in_ovr, in_unstable, out_ready;
  logic [23:0] in_value;
  logic        in_ready, out_valid;
  logic [23:0] out_word;

  int checks = 0;
  int errors = 0;
  int hold   = 0;

  always #2.5 clk = ~clk;

  adc_word_fmt u0 (
    .clk(clk), .rst(rst), .in_mode(in_mode), .in_valid(in_valid),
    .in_ready(in_ready), .in_value(in_value), .in_ovr(in_ovr),
    .in_unstable(in_unstable), .out_valid(out_valid),
    .out_ready(out_ready), .out_word(out_word)
  );

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [23:0] exp_word(int v, bit ovr, bit od, bit m16);
    int hi, lo, c;
    bit of;
    logic [31:0] cv;
    hi = m16 ? 32767 : 524287;
    lo = m16 ? -32768 : -524288;
    of = ovr || v > hi || v < lo;
    c  = v > hi ? hi : (v < lo ? lo : v);
    cv = c;
    if (m16) return {cv[15:0], 4'b0, 1'b0, of, od, 1'b0};
    return {cv[19:0], 1'b0, of, od, 1'b0};
  endfunction

  // One beat through the block; checks the word one cycle later.
  task automatic send(string req, int v, bit ovr, bit unst, bit m16);
    bit od;
    logic [31:0] vv;
    vv = v;
    od = unst || hold > 0;
    if (unst) hold = 4;
    else if (hold > 0) hold--;
    @(negedge clk);
    in_mode = m16; in_value = vv[23:0]; in_ovr = ovr; in_unstable = unst;
    in_valid = 1; out_ready = 1;
    @(negedge clk);
    in_valid = 0; in_ovr = 0; in_unstable = 0;
    chk({req, " out_valid"}, {23'b0, out_valid}, 24'd1);
    chk(req, out_word, exp_word(v, ovr, od, m16));
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1; in_valid = 0; out_ready = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    hold = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R10 out_valid after reset", {23'b0, out_valid}, 24'd0);
    chk("R10 out_word after reset", out_word, 24'd0);
    chk("R9 in_ready idle", {23'b0, in_ready}, 24'd1);
  endtask

  task automatic t_pack20();
    send("R1 pack20 positive", 32'h12345, 0, 0, 0);
    send("R1 pack20 negative", -5, 0, 0, 0);
    send("R1 pack20 zero", 0, 0, 0, 0);
  endtask

  task automatic t_sat20();
    send("R3 sat20 above top", 524288, 0, 0, 0);
    send("R3 sat20 below bottom", -524289, 0, 0, 0);
    send("R3 sat20 exact top", 524287, 0, 0, 0);
    send("R3 sat20 exact bottom", -524288, 0, 0, 0);
    send("R3 sat20 far above", 4000000, 0, 0, 0);
  endtask

  task automatic t_mode16();
    send("R2 pack16", 32'h1234, 0, 0, 1);
    send("R2 pack16 negative", -2, 0, 0, 1);
    send("R4 sat16 above", 40000, 0, 0, 1);
    send("R4 sat16 below", -40000, 0, 0, 1);
    send("R4 sat16 exact top", 32767, 0, 0, 1);
  endtask

  task automatic t_flags();
    send("R8 ovr only", 100, 1, 0, 0);
    send("R5 OF not sticky", 100, 0, 0, 0);
    send("R8 unstable only", 100, 0, 1, 0);
    for (int i = 0; i < 4; i++) send("R6 holdoff word", 7, 0, 0, 0);
    send("R6 fifth word clear", 7, 0, 0, 0);
    chk("R6 holdoff ended", {23'b0, out_word[1]}, 24'd0);
  endtask

  task automatic t_reload();
    send("R7 first unstable", 1, 0, 1, 1);
    send("R7 stable 1", 1, 0, 0, 1);
    send("R7 stable 2", 1, 0, 0, 1);
    send("R7 recurrence", 1, 0, 1, 1);
    for (int i = 0; i < 4; i++) send("R7 reloaded holdoff", 1, 0, 0, 1);
    send("R7 clear after reload", 1, 0, 0, 1);
    chk("R7 flag clear", {23'b0, out_word[1]}, 24'd0);
  endtask

  task automatic t_stall();
    logic [23:0] held;
    @(negedge clk);
    in_mode = 0; in_value = 24'h00ABC; in_ovr = 0; in_unstable = 0;
    in_valid = 1; out_ready = 0;
    @(negedge clk);
    held = out_word;
    chk("R9 stall word", held, exp_word(32'hABC, 0, 0, 0));
    chk("R9 in_ready low when full", {23'b0, in_ready}, 24'd0);
    in_value = 24'h00111; in_unstable = 1;
    repeat (3) @(negedge clk);
    chk("R9 word held during stall", out_word, held);
    chk("R9 valid held during stall", {23'b0, out_valid}, 24'd1);
    in_valid = 0; in_unstable = 0;
    out_ready = 1;
    @(negedge clk);
    chk("R9 drained", {23'b0, out_valid}, 24'd0);
    send("R9 refused beat left no flag", 5, 0, 0, 0);
  endtask

  task automatic t_reset_mid();
    send("R10 unstable before reset", 3, 0, 1, 0);
    do_reset();
    send("R10 stable after reset", 3, 0, 0, 0);
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst = 1; in_valid = 0; out_ready = 1; in_mode = 0;
    in_value = 0; in_ovr = 0; in_unstable = 0;
    t_reset();
    t_pack20();
    t_sat20();
    t_mode16();
    t_flags();
    t_reload();
    t_stall();
    t_reset_mid();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule